// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Generator

This block turns an angle into its cosine and sine with a cascade of shift-and-add micro-rotations. It is fully unrolled, so it takes a fresh angle on every clock. Each stage of the cascade rotates the working vector by a fixed arctangent step. Whether the step is added or subtracted depends on the sign of the angle that is still left to rotate. Every stage shifts by a fixed amount, done purely in wiring, and holds its arctangent constant as a literal. The working vector starts on the x axis at length 1/K, so the gain of the rotations brings the result to unit length without any multiplier.

Register slices sit between the adder stages. A parameter sets how many stages share one slice, so the same source can trade clock rate for latency. A valid flag travels beside the data through every slice. The result appears a fixed number of cycles after its angle went in, and that number equals the count of slices. A synchronous reset clears every valid flag in flight. The data registers themselves are not reset.

Angles are signed 32-bit binary angles, where one full turn is 2^32. The block covers -90 to +90 degrees, which is -2^30 to +2^30. Outputs are signed 32-bit values in which 1.0 is 2^30.

Top module: `cordic_pipe_rotator`

## Requirements
- R1: For any angle in [-2^30, +2^30], out_cos and out_sin are within 1024 LSB of cos and sin of angle*2*pi/2^32, scaled by 2^30.
- R2: A valid angle is accepted on every clock with no gap, and back-to-back results leave the pipe in the order their angles entered.
- R3: out_vld rises exactly LATENCY = ceil(ITER/REG_EVERY) cycles after in_vld was sampled high. This is 12 cycles for the defaults ITER=24 and REG_EVERY=2.
- R4: A cycle with in_vld low yields out_vld low LATENCY cycles later, whatever in_angle held.
- R5: While rst is high at a clock edge, every valid flag in the pipe is cleared, so out_vld stays low for every angle that was in flight at that edge or entered on it.
- R6: The edge angles give their exact values within tolerance. Angle 0 gives cos 2^30 and sin 0. Angle +2^30 gives cos 0 and sin +2^30, and angle -2^30 gives cos 0 and sin -2^30. Angles of +1 and -1 give cos 2^30 and sin 0.
- R7: Every valid result has |out_cos| and |out_sin| no larger than 2^30+1024, and out_cos no less than -1024. A positive angle gives out_sin greater than -1024, and a negative angle gives out_sin less than +1024.
- R8: Changing REG_EVERY changes only the latency. With REG_EVERY=3 the latency is 8 cycles, and the values match the same tolerance as R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| in_vld | input | 1 | Angle on in_angle is to be processed |
| in_angle | input | 32 | Signed binary angle, full turn = 2^32 |
| out_vld | output | 1 | out_cos and out_sin hold a result |
| out_cos | output | 32 | Signed cosine, 1.0 = 2^30 |
| out_sin | output | 32 | Signed sine, 1.0 = 2^30 |

## Verification
The bound checker's range and sign properties assume that every angle offered with in_vld high lies between -2^30 and +2^30. Outside that span the cascade does not converge, and the cosine sign rule would not hold. Every entry in the bench's vector table and every directed angle stays inside this span, including both end points. The bench also drives in_angle with in_vld low and during reset only to show that those values leave no trace. The checker keeps its own valid history and clears it on reset the same way, so a reset in the middle of a stream does not break the latency property.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam int DATA_W   = 32;
    localparam int MAX_ITER = 32;

    // 1.0 in output format
    localparam logic signed [DATA_W-1:0] UNIT_Q30 = 32'sd1073741824;
    // 2^30 divided by the accumulated rotation gain of the full cascade
    localparam logic signed [DATA_W-1:0] X_SEED   = 32'sd652032874;

    typedef struct packed {
        logic                     vld;
        logic signed [DATA_W-1:0] x;
        logic signed [DATA_W-1:0] y;
        logic signed [DATA_W-1:0] z;
    } cordic_word_t;

    // arctan(2^-k) as a binary angle, full turn = 2^32
    function automatic logic signed [DATA_W-1:0] step_angle(input int k);
        logic signed [DATA_W-1:0] a;
        case (k)
            0:  a = 32'sd536870912;
            1:  a = 32'sd316933406;
            2:  a = 32'sd167458907;
            3:  a = 32'sd85004756;
            4:  a = 32'sd42667331;
            5:  a = 32'sd21354465;
            6:  a = 32'sd10679838;
            7:  a = 32'sd5340245;
            8:  a = 32'sd2670163;
            9:  a = 32'sd1335087;
            10: a = 32'sd667544;
            11: a = 32'sd333772;
            12: a = 32'sd166886;
            13: a = 32'sd83443;
            14: a = 32'sd41722;
            15: a = 32'sd20861;
            16: a = 32'sd10430;
            17: a = 32'sd5215;
            18: a = 32'sd2608;
            19: a = 32'sd1304;
            20: a = 32'sd652;
            21: a = 32'sd326;
            22: a = 32'sd163;
            23: a = 32'sd81;
            24: a = 32'sd41;
            25: a = 32'sd20;
            26: a = 32'sd10;
            27: a = 32'sd5;
            28: a = 32'sd3;
            29: a = 32'sd1;
            30: a = 32'sd1;
            default: a = 32'sd0;
        endcase
        return a;
    endfunction

    // true when a register slice closes stage k
    function automatic bit slice_after(input int k, input int every, input int iters);
        return (((k + 1) % every) == 0) || (k == iters - 1);
    endfunction

endpackage

// File: rtl/cordic_micro_rot.sv
module cordic_micro_rot
    import cordic_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  cordic_word_t a_in,
    output cordic_word_t b_out
);

    localparam logic signed [DATA_W-1:0] STEP = step_angle(SHIFT);

    logic signed [DATA_W-1:0] x_cur;
    logic signed [DATA_W-1:0] y_cur;
    logic signed [DATA_W-1:0] z_cur;
    logic signed [DATA_W-1:0] x_scaled;
    logic signed [DATA_W-1:0] y_scaled;
    logic                     turn_neg;

    always_comb begin
        x_cur    = a_in.x;
        y_cur    = a_in.y;
        z_cur    = a_in.z;
        // fixed shift: pure wiring with sign extension
        x_scaled = x_cur >>> SHIFT;
        y_scaled = y_cur >>> SHIFT;
        turn_neg = z_cur[DATA_W-1];
    end

    always_comb begin
        b_out.vld = a_in.vld;
        if (turn_neg) begin
            b_out.x = x_cur + y_scaled;
            b_out.y = y_cur - x_scaled;
            b_out.z = z_cur + STEP;
        end else begin
            b_out.x = x_cur - y_scaled;
            b_out.y = y_cur + x_scaled;
            b_out.z = z_cur - STEP;
        end
    end

endmodule

// File: rtl/cordic_slice.sv
module cordic_slice
    import cordic_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  cordic_word_t d_in,
    output cordic_word_t q_out
);

    // only the valid flag is reset; data simply follows
    always_ff @(posedge clk) begin
        if (rst) begin
            q_out.vld <= 1'b0;
        end else begin
            q_out.vld <= d_in.vld;
        end
    end

    always_ff @(posedge clk) begin
        q_out.x <= d_in.x;
        q_out.y <= d_in.y;
        q_out.z <= d_in.z;
    end

endmodule

// File: rtl/cordic_pipe_rotator.sv
module cordic_pipe_rotator
    import cordic_pkg::*;
#(
    parameter int ITER      = 24,
    parameter int REG_EVERY = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] in_angle,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_cos,
    output logic signed [DATA_W-1:0] out_sin
);

    localparam int LATENCY = (ITER + REG_EVERY - 1) / REG_EVERY;

    // link[k] feeds stage k; link[ITER] is the pipe output
    cordic_word_t link [0:ITER];
    cordic_word_t comb_out [0:ITER-1];

    always_comb begin
        link[0].vld = in_vld;
        link[0].x   = X_SEED;
        link[0].y   = '0;
        link[0].z   = in_angle;
    end

    for (genvar k = 0; k < ITER; k++) begin : g_stage
        cordic_micro_rot #(
            .SHIFT (k)
        ) u_rot (
            .a_in  (link[k]),
            .b_out (comb_out[k])
        );

        if (slice_after(k, REG_EVERY, ITER)) begin : g_reg
            cordic_slice u_slice (
                .clk   (clk),
                .rst   (rst),
                .d_in  (comb_out[k]),
                .q_out (link[k+1])
            );
        end else begin : g_wire
            assign link[k+1] = comb_out[k];
        end
    end

    always_comb begin
        out_vld = link[ITER].vld;
        out_cos = link[ITER].x;
        out_sin = link[ITER].y;
    end

endmodule

// File: rtl/cordic_rotator_checker.sv
module cordic_rotator_checker #(
    parameter int LATENCY = 12,
    parameter int TOL     = 1024
) (
    input logic               clk,
    input logic               rst,
    input logic               in_vld,
    input logic signed [31:0] in_angle,
    input logic               out_vld,
    input logic signed [31:0] out_cos,
    input logic signed [31:0] out_sin
);

    localparam logic signed [31:0] UNIT  = 32'sd1073741824;
    localparam logic signed [31:0] LIMIT = UNIT + TOL;

    logic [LATENCY-1:0] seen_vld;
    logic [LATENCY-1:0] seen_pos;
    logic [LATENCY-1:0] seen_neg;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_vld <= '0;
            seen_pos <= '0;
            seen_neg <= '0;
        end else begin
            seen_vld[0] <= in_vld;
            seen_pos[0] <= in_vld && !in_angle[31] && (in_angle != 0);
            seen_neg[0] <= in_vld && in_angle[31];
            for (int k = 1; k < LATENCY; k++) begin
                seen_vld[k] <= seen_vld[k-1];
                seen_pos[k] <= seen_pos[k-1];
                seen_neg[k] <= seen_neg[k-1];
            end
        end
    end

    // R3 / R4: output valid is the input valid delayed by the pipe depth
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        out_vld == seen_vld[LATENCY-1]);

    // R5: a reset edge leaves no valid result behind it
    a_r5_reset_clears: assert property (@(posedge clk)
        rst |=> !out_vld);

    // R7: bounded magnitude
    a_r7_bounded: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_cos <= LIMIT) && (out_cos >= -LIMIT)
                 && (out_sin <= LIMIT) && (out_sin >= -LIMIT));

    // R1: cosine is non-negative across the covered half circle
    a_r1_cos_nonneg: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_cos > -TOL);

    // R7: sine follows the sign of the angle
    a_r7_sin_pos: assert property (@(posedge clk) disable iff (rst)
        (out_vld && seen_pos[LATENCY-1]) |-> out_sin > -TOL);

    a_r7_sin_neg: assert property (@(posedge clk) disable iff (rst)
        (out_vld && seen_neg[LATENCY-1]) |-> out_sin < TOL);

endmodule

bind cordic_pipe_rotator cordic_rotator_checker #(
    .LATENCY (LATENCY),
    .TOL     (1024)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_angle (in_angle),
    .out_vld  (out_vld),
    .out_cos  (out_cos),
    .out_sin  (out_sin)
);

// File: tb/test_cordic_pipe_rotator.sv
module test_cordic_pipe_rotator;

    localparam int CLK_PERIOD = 10;
    localparam int ITER       = 24;
    localparam int SPC_A      = 2;
    localparam int SPC_B      = 3;
    localparam int LAT_A      = (ITER + SPC_A - 1) / SPC_A;
    localparam int LAT_B      = (ITER + SPC_B - 1) / SPC_B;
    localparam int TOL        = 1024;
    localparam real ONE       = 1073741824.0;
    localparam int MAXC       = 1024;
    localparam int NVEC       = 16;

    // stimulus table: angle, expected sine sign, requirement tag
    localparam int VEC_ANG [NVEC] = '{
        0, 1073741824, -1073741824, 536870912, -536870912, 178956971,
        357913941, 715827883, -357913941, 1, -1, 1000000000,
        -1000000000, 123456789, 894784853, -715827883 };
    localparam int VEC_SGN [NVEC] = '{
        0, 1, -1, 1, -1, 1, 1, 1, -1, 0, 0, 1, -1, 1, 1, -1 };
    localparam int VEC_TAG [NVEC] = '{
        6, 6, 6, 1, 1, 1, 1, 1, 1, 6, 6, 1, 1, 1, 1, 1 };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_vld = 1'b0;
    logic signed [31:0] in_angle = '0;
    logic               a_vld, b_vld;
    logic signed [31:0] a_cos, a_sin, b_cos, b_sin;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  done    = 1'b0;

    bit  h_vld [MAXC];
    int  h_ang [MAXC];
    int  h_sgn [MAXC];
    int  h_tag [MAXC];
    bit  rst_at [MAXC];

    always #(CLK_PERIOD/2) clk = ~clk;

    cordic_pipe_rotator #(.ITER(ITER), .REG_EVERY(SPC_A)) i_cordic_pipe_rotator (
        .clk (clk), .rst (rst), .in_vld (in_vld), .in_angle (in_angle),
        .out_vld (a_vld), .out_cos (a_cos), .out_sin (a_sin));

    cordic_pipe_rotator #(.ITER(ITER), .REG_EVERY(SPC_B)) i_cordic_pipe_rotator_s3 (
        .clk (clk), .rst (rst), .in_vld (in_vld), .in_angle (in_angle),
        .out_vld (b_vld), .out_cos (b_cos), .out_sin (b_sin));

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc < MAXC) rst_at[cyc] = rst;
    end

    function automatic string tag_name(input int t);
        case (t)
            2:       return "R2";
            6:       return "R6";
            default: return "R1";
        endcase
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic check_out(input int lat, input logic vld,
                             input int cosv, input int sinv, input bit is_b);
        int    d;
        bit    killed;
        bit    expv;
        real   rad;
        int    ec, es;
        string lab;
        d = cyc - lat;
        killed = 1'b0;
        for (int p = d + 1; p <= d + lat; p++) if (rst_at[p]) killed = 1'b1;
        expv = h_vld[d] && !killed;
        if (is_b)                   lab = "R8";
        else if (h_vld[d] && killed) lab = "R5";
        else if (expv)              lab = "R3";
        else                        lab = "R4";
        n_tests++;
        if (vld !== expv) begin
            n_fail++;
            $display("FAIL %s valid at cycle %0d: got %0b expected %0b", lab, cyc, vld, expv);
        end
        if (expv && vld === 1'b1) begin
            rad = real'(h_ang[d]) * 6.283185307179586 / 4294967296.0;
            ec  = int'($cos(rad) * ONE);
            es  = int'($sin(rad) * ONE);
            lab = is_b ? "R8" : tag_name(h_tag[d]);
            n_tests++;
            if (absdiff(cosv, ec) > TOL || absdiff(sinv, es) > TOL) begin
                n_fail++;
                $display("FAIL %s angle %0d: got cos %0d sin %0d expected cos %0d sin %0d",
                         lab, h_ang[d], cosv, sinv, ec, es);
            end
            // R7 range and sign
            n_tests++;
            if (cosv > 1073741824 + TOL || cosv < -TOL ||
                sinv > 1073741824 + TOL || sinv < -1073741824 - TOL ||
                (h_sgn[d] > 0 && sinv <= -TOL) || (h_sgn[d] < 0 && sinv >= TOL)) begin
                n_fail++;
                $display("FAIL R7 angle %0d: got cos %0d sin %0d expected bounded with sine sign %0d",
                         h_ang[d], cosv, sinv, h_sgn[d]);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!done && cyc < MAXC) begin
            if (cyc >= LAT_A) check_out(LAT_A, a_vld, a_cos, a_sin, 1'b0);
            if (cyc >= LAT_B) check_out(LAT_B, b_vld, b_cos, b_sin, 1'b1);
        end
    end

    task automatic drive(input bit v, input int ang, input int sgn, input int tag);
        @(negedge clk);
        in_vld   = v;
        in_angle = ang;
        if (cyc < MAXC) begin
            h_vld[cyc] = v;
            h_ang[cyc] = ang;
            h_sgn[cyc] = sgn;
            h_tag[cyc] = tag;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 32'h5A5A_1234, 0, 1);
    endtask

    initial begin
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        // R5: reset state
        @(negedge clk);
        n_tests++;
        if (a_vld !== 1'b0 || b_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 reset state: got %0b/%0b expected 0/0", a_vld, b_vld);
        end
        h_vld[cyc] = 1'b0;
        in_vld = 1'b0;

        // table with bubbles between entries (R1, R4, R6)
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VEC_ANG[i], VEC_SGN[i], VEC_TAG[i]);
            drive(1'b0, -VEC_ANG[i], 0, 1);
        end
        idle(LAT_A + 2);

        // same table back to back (R2)
        for (int i = 0; i < NVEC; i++) drive(1'b1, VEC_ANG[i], VEC_SGN[i], 2);
        idle(LAT_A + 2);

        // reset in the middle of a stream (R5)
        for (int i = 0; i < 6; i++) drive(1'b1, VEC_ANG[i + 3], VEC_SGN[i + 3], 1);
        rst = 1'b1;
        drive(1'b1, 357913941, 1, 1);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) drive(1'b1, VEC_ANG[i + 6], VEC_SGN[i + 6], 2);
        idle(LAT_A + 3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule